// File: doc/BRIEF.md
# Output Buffer Full and Interrupt Arbiter

This block sits between two byte channels of a legacy keyboard/mouse controller and the host side of that controller. One channel carries keyboard data and the other carries auxiliary (pointing device) data. Each channel raises a level while it holds a byte that the host has not read yet. The block registers those two levels into a two-bit pending state. From that state and the controller's mode register it derives several results:

- the buffer-full flags in the status register;
- the copies of those flags in the output port;
- two level interrupt requests, one for each channel;
- the select that tells the data-port read path which channel supplies the next byte.

The keyboard channel always wins. The auxiliary flags, the auxiliary interrupt and the auxiliary read select assert only when auxiliary data is the only data waiting. The keyboard interrupt is enabled by one mode bit and is also gated off by the keyboard-disable mode bit. The other status and output-port bits come from the registers that own them and pass through unchanged. The block forces only the four buffer-full bits.

Top module: `obf_irq_arbiter`

## Requirements
- R1: While reset is asserted (rst_n low), the pending state is clear, whatever the channel levels are. In that state both interrupts, the read select and all four buffer-full bits are low.
- R2: Each channel level is sampled on the rising clock edge. A change on kbd_avail or aux_avail reaches the outputs after that edge and not before it.
- R3: stat_out bit 0 and oport_out bit 4 are high exactly when at least one channel is pending.
- R4: stat_out bit 5 and oport_out bit 5 are high exactly when auxiliary data is pending and keyboard data is not.
- R5: irq_aux is high exactly when auxiliary data is the only pending source and mode_in bit 1 is set.
- R6: irq_kbd is high exactly when keyboard data is pending, mode_in bit 0 is set and mode_in bit 4 is clear. This holds whether or not auxiliary data is also pending.
- R7: rd_sel_aux (1 = auxiliary channel, 0 = keyboard channel) is high exactly when auxiliary data is the only pending source.
- R8: Status bits 1-4, 6 and 7 equal stat_in. Output-port bits 0-3, 6 and 7 equal oport_in.
- R9: A change on mode_in or on the pass-through inputs shows on the outputs in the same cycle, without waiting for a clock edge.
- R10: When neither channel is pending, both interrupts and all four buffer-full bits are low for every mode value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| kbd_avail | input | 1 | Keyboard channel holds an unread byte |
| aux_avail | input | 1 | Auxiliary channel holds an unread byte |
| mode_in | input | REG_W | Controller mode register (bit 0 keyboard irq enable, bit 1 aux irq enable, bit 4 keyboard disable) |
| stat_in | input | REG_W | Status register bits owned elsewhere |
| oport_in | input | REG_W | Output-port bits owned elsewhere |
| stat_out | output | REG_W | Status register with buffer-full bits 0 and 5 applied |
| oport_out | output | REG_W | Output port with buffer-full bits 4 and 5 applied |
| irq_kbd | output | 1 | Keyboard interrupt request level |
| irq_aux | output | 1 | Auxiliary interrupt request level |
| rd_sel_aux | output | 1 | Data-port read source select |

## Verification
The assertions check on every cycle the relations that do not depend on the mode:

- a sampled channel level shows in the buffer-full flags one edge later;
- a keyboard byte hides all auxiliary indications;
- the two interrupts never assert together;
- an auxiliary interrupt always comes with the auxiliary read select.

The mode gating of each interrupt, the same-cycle response to a mode write and the pass-through of the bits owned elsewhere can be shown only by the bench's scenarios. The bench compares every output against its reference model for all four pending combinations under a range of mode values.

// File: rtl/obf_irq_arbiter.sv
module obf_irq_arbiter #(
  parameter int REG_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             kbd_avail,
  input  logic             aux_avail,
  input  logic [REG_W-1:0] mode_in,
  input  logic [REG_W-1:0] stat_in,
  input  logic [REG_W-1:0] oport_in,
  output logic [REG_W-1:0] stat_out,
  output logic [REG_W-1:0] oport_out,
  output logic             irq_kbd,
  output logic             irq_aux,
  output logic             rd_sel_aux
);

  localparam int STAT_FULL = 0;
  localparam int STAT_AUX  = 5;
  localparam int PORT_FULL = 4;
  localparam int PORT_AUX  = 5;
  localparam int MODE_KIE  = 0;
  localparam int MODE_AIE  = 1;
  localparam int MODE_KOFF = 4;

  logic kbd_pend_q, aux_pend_q;
  logic any_pend, aux_only;
  logic unused_mode;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      kbd_pend_q <= 1'b0;
      aux_pend_q <= 1'b0;
    end else begin
      kbd_pend_q <= kbd_avail;
      aux_pend_q <= aux_avail;
    end
  end

  assign any_pend = kbd_pend_q | aux_pend_q;
  assign aux_only = aux_pend_q & ~kbd_pend_q;

  always_comb begin
    stat_out             = stat_in;
    stat_out[STAT_FULL]  = any_pend;
    stat_out[STAT_AUX]   = aux_only;
    oport_out            = oport_in;
    oport_out[PORT_FULL] = any_pend;
    oport_out[PORT_AUX]  = aux_only;
  end

  assign irq_kbd     = kbd_pend_q & mode_in[MODE_KIE] & ~mode_in[MODE_KOFF];
  assign irq_aux     = aux_only & mode_in[MODE_AIE];
  assign rd_sel_aux  = aux_only;
  assign unused_mode = ^mode_in;

  // R2 R3
  kbd_seen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    kbd_avail |=> (stat_out[STAT_FULL] && oport_out[PORT_FULL]));

  // R4 R7
  kbd_hides_aux_chk: assert property (@(posedge clk) disable iff (!rst_n)
    kbd_avail |=> (!stat_out[STAT_AUX] && !oport_out[PORT_AUX] && !rd_sel_aux && !irq_aux));

  // R7
  aux_alone_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (aux_avail && !kbd_avail) |=> (rd_sel_aux && stat_out[STAT_AUX]));

  // R10
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!aux_avail && !kbd_avail) |=> (!irq_kbd && !irq_aux && !stat_out[STAT_FULL] && !oport_out[PORT_AUX]));

  // R5 R6
  irq_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({irq_kbd, irq_aux}));

  // R5
  irq_aux_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_aux |-> rd_sel_aux);

endmodule

// File: tb/tb_obf_irq_arbiter.sv
module tb_obf_irq_arbiter;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       kbd_avail = 1'b0, aux_avail = 1'b0;
  logic [7:0] mode_in = 8'h03, stat_in = 8'h18, oport_in = 8'h03;
  logic [7:0] stat_out, oport_out;
  logic       irq_kbd, irq_aux, rd_sel_aux;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;
  bit m_k = 1'b0, m_a = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  obf_irq_arbiter #(.REG_W(8)) dut (
    .clk(clk), .rst_n(rst_n), .kbd_avail(kbd_avail), .aux_avail(aux_avail),
    .mode_in(mode_in), .stat_in(stat_in), .oport_in(oport_in),
    .stat_out(stat_out), .oport_out(oport_out),
    .irq_kbd(irq_kbd), .irq_aux(irq_aux), .rd_sel_aux(rd_sel_aux));

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin m_k <= 1'b0; m_a <= 1'b0; end
    else begin m_k <= kbd_avail; m_a <= aux_avail; end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    bit any_p, solo;
    any_p = m_k || m_a;
    solo  = m_a && !m_k;
    chk("R3 stat bit0", stat_out[0], any_p);
    chk("R3 oport bit4", oport_out[4], any_p);
    chk("R4 stat bit5", stat_out[5], solo);
    chk("R4 oport bit5", oport_out[5], solo);
    chk("R5 irq_aux", irq_aux, solo && mode_in[1]);
    chk("R6 irq_kbd", irq_kbd, m_k && mode_in[0] && !mode_in[4]);
    chk("R7 rd_sel_aux", rd_sel_aux, solo);
    chk("R8 stat passthrough", stat_out & 8'hDE, stat_in & 8'hDE);
    chk("R8 oport passthrough", oport_out & 8'hCF, oport_in & 8'hCF);
    if (!any_p) chk("R10 idle", {irq_kbd, irq_aux, stat_out[0], stat_out[5], oport_out[4], oport_out[5]}, 0);
  endtask

  always @(posedge clk) begin
    #(CLK_PERIOD/4);
    if (rst_n && !done) compare_all();
  end

  task automatic drive(input bit k, input bit a, input logic [7:0] m);
    @(negedge clk);
    kbd_avail = k; aux_avail = a; mode_in = m;
    stat_in = 8'($urandom); oport_in = 8'($urandom);
  endtask

  initial begin
    #(CLK_PERIOD*100000);
    failures++;
    $display("FAIL watchdog expired");
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [7:0] modes [6] = '{8'h03, 8'h13, 8'h00, 8'h01, 8'h02, 8'h11};
    kbd_avail = 1'b1; aux_avail = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    chk("R1 reset outputs", {irq_kbd, irq_aux, rd_sel_aux, stat_out[0], stat_out[5], oport_out[4], oport_out[5]}, 0);
    @(negedge clk);
    kbd_avail = 1'b0; aux_avail = 1'b0; rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R2: level change becomes visible only after the next rising edge
    kbd_avail = 1'b1;
    #1 chk("R2 before edge", stat_out[0], 0);
    @(posedge clk); #1 chk("R2 after edge", stat_out[0], 1);

    // R9: mode change acts without a clock edge
    @(negedge clk); mode_in = 8'h13;
    #1 chk("R9 kbd disable same cycle", irq_kbd, 0);
    mode_in = 8'h03;
    #1 chk("R9 kbd enable same cycle", irq_kbd, 1);
    stat_in = 8'hFF;
    #1 chk("R9 R8 passthrough same cycle", stat_out & 8'hDE, 8'hDE);

    foreach (modes[i]) begin
      for (int p = 0; p < 4; p++) begin
        drive(p[0], p[1], modes[i]);
        drive(p[0], p[1], modes[i]);
      end
    end

    // R6: keyboard irq under both pending with keyboard disabled
    drive(1'b1, 1'b1, 8'h13);
    @(posedge clk); #1 chk("R6 disabled with both", {irq_kbd, irq_aux}, 0);

    // R10: idle under all-ones mode
    drive(1'b0, 1'b0, 8'hFF);
    @(posedge clk); #1 chk("R10 idle mode ff", {irq_kbd, irq_aux, stat_out[0], oport_out[4]}, 0);

    for (int n = 0; n < 400; n++) begin
      int r;
      r = $urandom;
      drive(r[0], r[1], 8'(r >> 8));
    end
    @(negedge clk);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule